// File: doc/BRIEF.md
# Register-Mapped SPI Master with Byte Queues

This block is a byte-oriented SPI master that software drives through a 32-bit word register port. Bytes written to the transmit data register go into a transmit queue. A shift engine pops one byte at a time and sends it most significant bit first on `mosi`. During the same eight clocks it captures eight bits from `miso` and pushes the captured byte into a receive queue. Software pops the receive queue by reading the receive data register.

A control register holds a transfer-inhibit bit. While that bit is set, queued bytes wait; clearing it drains the queue back-to-back. Two write-only control bits empty the queues. A status register reports whether each queue is empty or full, and two occupancy registers report the fill level. A slave-select register drives active-low chip selects directly. Writing one magic word to the soft-reset register puts everything back to its power-up state.

The bus runs in mode 0: `sclk` idles low, `miso` is sampled on the rising edge and `mosi` changes on the falling edge. Two single-cycle strobes go to an interrupt block: one when a receive push fills the queue, and one when a finished byte is dropped because the queue was already full.

Top module: `spi_fifo_master`

## Requirements
- R1: After `rstN` is released, the registers read as follows. Control (byte address 0x60) is 0. Status (0x64) is 0x5. Both occupancy registers (0x74 transmit, 0x78 receive) are 0. Slave select (0x70) is 0xFFFFFFFF and every `ssN` line is high.
- R2: Writing exactly 0x0000000A to address 0x40 does all of the following: clears control, empties both queues, aborts any byte in flight and sets slave select to all ones. Writing any other value to 0x40 changes nothing.
- R3: A write to 0x68 queues bits [7:0] of the written word. If the transmit queue already holds DEPTH bytes, the write is dropped and the queued contents stay as they were.
- R4: Each byte is sent MSB first in mode 0. `sclk` has a period of DIV system clocks. `mosi` is stable at every rising edge. The eight `miso` bits sampled on the rising edges form the byte pushed into the receive queue.
- R5: Control bit 8 inhibits transfers. While it is 1, no new byte starts. While it is 0, queued bytes are sent one after another until the queue is empty.
- R6: A control write with bit 5 set empties the transmit queue, and one with bit 6 set empties the receive queue. Neither bit is stored, so both read back as 0.
- R7: The status bits are: bit 0 receive empty, bit 1 receive full, bit 2 transmit empty, bit 3 transmit full, all other bits 0. Writes to 0x64 have no effect.
- R8: When a byte finishes while the receive queue is full, the byte is discarded and `evtRxOverrun` pulses for one cycle. When a push brings the receive queue to DEPTH entries, `evtRxFull` pulses for one cycle.
- R9: A read of 0x6C with an empty receive queue returns 0xDEADBEEF and pops nothing. Otherwise it returns the oldest byte in bits [7:0] and pops it.
- R10: Each occupancy register reads as the entry count minus one, or 0 when its queue is empty.
- R11: `ssN[i]` is low exactly when bit i of the slave-select register is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWrEn | input | 1 | Register write strobe, one per word |
| regRdEn | input | 1 | Register read strobe; a read of 0x6C pops at the clock edge |
| regAddr | input | 7 | Byte address of the word register |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Read data, valid combinationally for the current address |
| sclk | output | 1 | SPI clock, idle low |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| ssN | output | NUM_CS | Active-low chip selects |
| evtRxFull | output | 1 | Pulse: a push filled the receive queue |
| evtRxOverrun | output | 1 | Pulse: a finished byte was dropped on a full queue |

## Verification
The assertions take three things for granted about the inputs. A read or write strobe lasts exactly one cycle. Every address is word aligned. `miso` changes only after the rising `sclk` edge at which it is sampled. The stimulus keeps to these by issuing each register access as a single-cycle pulse driven between edges. An attached slave model drives `miso` only when it sees `sclk` rise. Queue flushes and soft resets are issued only while the engine is idle, so no byte is cut off mid-flight.

// File: rtl/spim_pkg.sv
package spim_pkg;
  localparam int ADDR_W = 7;

  localparam logic [ADDR_W-1:0] OFF_SRST  = 7'h40;
  localparam logic [ADDR_W-1:0] OFF_CTRL  = 7'h60;
  localparam logic [ADDR_W-1:0] OFF_STAT  = 7'h64;
  localparam logic [ADDR_W-1:0] OFF_TXD   = 7'h68;
  localparam logic [ADDR_W-1:0] OFF_RXD   = 7'h6C;
  localparam logic [ADDR_W-1:0] OFF_SSEL  = 7'h70;
  localparam logic [ADDR_W-1:0] OFF_TXOCC = 7'h74;
  localparam logic [ADDR_W-1:0] OFF_RXOCC = 7'h78;

  localparam logic [31:0] SRST_MAGIC  = 32'h0000_000A;
  localparam logic [31:0] EMPTY_MARK  = 32'hDEAD_BEEF;
  localparam int          BIT_TXFLUSH = 5;
  localparam int          BIT_RXFLUSH = 6;
  localparam int          BIT_INHIBIT = 8;

  // control -> datapath strobes
  typedef struct packed {
    logic       txPush;
    logic [7:0] txData;
    logic       rxPop;
    logic       txFlush;
    logic       rxFlush;
    logic       abort;
    logic       inhibit;
  } spimStrobes_t;
endpackage

// File: rtl/spim_fifo.sv
module spim_fifo #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 16,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             flush,
  input  logic             push,
  input  logic [WIDTH-1:0] pushData,
  input  logic             pop,
  output logic [WIDTH-1:0] popData,
  output logic [CNT_W-1:0] count,
  output logic             full,
  output logic             empty
);
  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr;
  logic doPush, doPop;

  assign full    = (count == CNT_W'(DEPTH));
  assign empty   = (count == '0);
  assign doPush  = push && !full;
  assign doPop   = pop && !empty;
  assign popData = mem[rdPtr];

  function automatic logic [PTR_W-1:0] nextPtr(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else if (flush) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (doPush) wrPtr <= nextPtr(wrPtr);
      if (doPop)  rdPtr <= nextPtr(rdPtr);
      case ({doPush, doPop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (doPush && !flush) mem[wrPtr] <= pushData;
  end

  // R3: a push into a full queue leaves the fill level untouched
  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rstN)
    (push && full && !pop && !flush) |=> (count == $past(count)));

  // R9: popping an empty queue leaves it empty
  p_no_underflow_r9: assert property (@(posedge clk) disable iff (!rstN)
    (pop && empty && !push && !flush) |=> empty);
endmodule

// File: rtl/spim_ctrl.sv
module spim_ctrl
  import spim_pkg::*;
#(
  parameter int NUM_CS = 1,
  parameter int DEPTH  = 16,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [31:0]       regWrData,
  output logic [31:0]       regRdData,
  output logic [NUM_CS-1:0] ssN,
  output spimStrobes_t      str,
  input  logic [CNT_W-1:0]  txCount,
  input  logic [CNT_W-1:0]  rxCount,
  input  logic              txFull,
  input  logic              txEmpty,
  input  logic              rxFull,
  input  logic              rxEmpty,
  input  logic [7:0]        rxData
);
  localparam logic [31:0] FLUSH_MASK = (32'd1 << BIT_TXFLUSH) | (32'd1 << BIT_RXFLUSH);

  logic [31:0] ctrlReg, sselReg;
  logic softRst, ctrlWr;

  assign softRst = regWrEn && (regAddr == OFF_SRST) && (regWrData == SRST_MAGIC);
  assign ctrlWr  = regWrEn && (regAddr == OFF_CTRL);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlReg <= '0;
      sselReg <= '1;
    end else if (softRst) begin
      ctrlReg <= '0;
      sselReg <= '1;
    end else if (regWrEn) begin
      if (regAddr == OFF_CTRL) ctrlReg <= regWrData & ~FLUSH_MASK;
      if (regAddr == OFF_SSEL) sselReg <= regWrData;
    end
  end

  assign ssN = sselReg[NUM_CS-1:0];

  always_comb begin
    str         = '0;
    str.txPush  = regWrEn && (regAddr == OFF_TXD);
    str.txData  = regWrData[7:0];
    str.rxPop   = regRdEn && (regAddr == OFF_RXD) && !rxEmpty;
    str.txFlush = softRst || (ctrlWr && regWrData[BIT_TXFLUSH]);
    str.rxFlush = softRst || (ctrlWr && regWrData[BIT_RXFLUSH]);
    str.abort   = softRst;
    str.inhibit = ctrlReg[BIT_INHIBIT];
  end

  function automatic logic [31:0] occ(input logic [CNT_W-1:0] c);
    return (c == '0) ? 32'd0 : (32'(c) - 32'd1);
  endfunction

  always_comb begin
    case (regAddr)
      OFF_CTRL:  regRdData = ctrlReg;
      OFF_STAT:  regRdData = {28'd0, txFull, txEmpty, rxFull, rxEmpty};
      OFF_RXD:   regRdData = rxEmpty ? EMPTY_MARK : {24'd0, rxData};
      OFF_SSEL:  regRdData = sselReg;
      OFF_TXOCC: regRdData = occ(txCount);
      OFF_RXOCC: regRdData = occ(rxCount);
      default:   regRdData = '0;
    endcase
  end

  // R6: the flush bits never land in the stored control word
  p_flush_bits_clear_r6: assert property (@(posedge clk) disable iff (!rstN)
    ctrlWr |=> (regRdData[BIT_TXFLUSH] == 1'b0 || regAddr != OFF_CTRL));

  // R2: after a magic soft reset every chip select is released
  p_srst_release_r2: assert property (@(posedge clk) disable iff (!rstN)
    softRst |=> (&ssN));
endmodule

// File: rtl/spim_datapath.sv
module spim_datapath
  import spim_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int DIV   = 4,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int HALF  = (DIV / 2 > 0) ? DIV / 2 : 1,
  localparam int HW    = (HALF > 1) ? $clog2(HALF) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  spimStrobes_t     str,
  input  logic             miso,
  output logic             sclk,
  output logic             mosi,
  output logic [CNT_W-1:0] txCount,
  output logic [CNT_W-1:0] rxCount,
  output logic             txFull,
  output logic             txEmpty,
  output logic             rxFull,
  output logic             rxEmpty,
  output logic [7:0]       rxData,
  output logic             evtRxFull,
  output logic             evtRxOverrun
);
  logic [7:0]    txByte, txSh, rxSh;
  logic [2:0]    bitCnt;
  logic [HW-1:0] divCnt;
  logic          busy, sclkQ, startOk, halfDone, byteDone, rxPushOk;

  spim_fifo #(.WIDTH(8), .DEPTH(DEPTH)) uTxFifo (
    .clk(clk), .rstN(rstN), .flush(str.txFlush),
    .push(str.txPush), .pushData(str.txData),
    .pop(startOk), .popData(txByte),
    .count(txCount), .full(txFull), .empty(txEmpty)
  );

  spim_fifo #(.WIDTH(8), .DEPTH(DEPTH)) uRxFifo (
    .clk(clk), .rstN(rstN), .flush(str.rxFlush),
    .push(rxPushOk), .pushData(rxSh),
    .pop(str.rxPop), .popData(rxData),
    .count(rxCount), .full(rxFull), .empty(rxEmpty)
  );

  assign startOk  = !busy && !str.inhibit && !txEmpty && !str.txFlush && !str.abort;
  assign halfDone = (divCnt == HW'(HALF - 1));
  assign byteDone = busy && sclkQ && halfDone && (bitCnt == 3'd7) && !str.abort;
  assign rxPushOk = byteDone && !rxFull;

  assign evtRxOverrun = byteDone && rxFull;
  assign evtRxFull    = rxPushOk && !str.rxPop && !str.rxFlush &&
                        (rxCount == CNT_W'(DEPTH - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy   <= 1'b0;
      sclkQ  <= 1'b0;
      txSh   <= '0;
      rxSh   <= '0;
      bitCnt <= '0;
      divCnt <= '0;
    end else if (str.abort) begin
      busy   <= 1'b0;
      sclkQ  <= 1'b0;
      bitCnt <= '0;
      divCnt <= '0;
    end else if (!busy) begin
      if (startOk) begin
        busy   <= 1'b1;
        txSh   <= txByte;
        bitCnt <= '0;
        divCnt <= '0;
      end
    end else if (halfDone) begin
      divCnt <= '0;
      if (!sclkQ) begin
        sclkQ <= 1'b1;
        rxSh  <= {rxSh[6:0], miso};
      end else begin
        sclkQ <= 1'b0;
        if (bitCnt == 3'd7) begin
          busy <= 1'b0;
        end else begin
          bitCnt <= bitCnt + 1'b1;
          txSh   <= {txSh[6:0], 1'b0};
        end
      end
    end else begin
      divCnt <= divCnt + 1'b1;
    end
  end

  assign sclk = sclkQ;
  assign mosi = busy ? txSh[7] : 1'b0;

  // R4: the clock idles low between bytes
  p_sclk_idle_low_r4: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !sclkQ);

  // R4: data out holds still across every rising clock edge
  p_mosi_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $rose(sclkQ)) |-> $stable(mosi));

  // R5: no byte starts while transfers are inhibited
  p_inhibit_no_start_r5: assert property (@(posedge clk) disable iff (!rstN)
    (str.inhibit && !busy) |=> !busy);

  // R8: a dropped byte does not change the receive fill level
  p_overrun_drops_r8: assert property (@(posedge clk) disable iff (!rstN)
    (evtRxOverrun && !str.rxPop && !str.rxFlush) |=> (rxCount == $past(rxCount)));

  // R9: the control side never pops an empty receive queue
  p_no_pop_empty_r9: assert property (@(posedge clk) disable iff (!rstN)
    str.rxPop |-> !rxEmpty);

  // R6: a transmit flush leaves the queue empty
  p_tx_flush_r6: assert property (@(posedge clk) disable iff (!rstN)
    (str.txFlush && !str.txPush) |=> txEmpty);
endmodule

// File: rtl/spi_fifo_master.sv
module spi_fifo_master
  import spim_pkg::*;
#(
  parameter int NUM_CS = 1,
  parameter int DEPTH  = 16,
  parameter int DIV    = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [6:0]        regAddr,
  input  logic [31:0]       regWrData,
  output logic [31:0]       regRdData,
  output logic              sclk,
  output logic              mosi,
  input  logic              miso,
  output logic [NUM_CS-1:0] ssN,
  output logic              evtRxFull,
  output logic              evtRxOverrun
);
  localparam int CNT_W = $clog2(DEPTH + 1);

  spimStrobes_t     str;
  logic [CNT_W-1:0] txCount, rxCount;
  logic             txFull, txEmpty, rxFull, rxEmpty;
  logic [7:0]       rxData;

  spim_ctrl #(.NUM_CS(NUM_CS), .DEPTH(DEPTH)) uCtrl (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData),
    .ssN(ssN), .str(str), .txCount(txCount), .rxCount(rxCount),
    .txFull(txFull), .txEmpty(txEmpty), .rxFull(rxFull), .rxEmpty(rxEmpty),
    .rxData(rxData)
  );

  spim_datapath #(.DEPTH(DEPTH), .DIV(DIV)) uData (
    .clk(clk), .rstN(rstN), .str(str), .miso(miso), .sclk(sclk), .mosi(mosi),
    .txCount(txCount), .rxCount(rxCount), .txFull(txFull), .txEmpty(txEmpty),
    .rxFull(rxFull), .rxEmpty(rxEmpty), .rxData(rxData),
    .evtRxFull(evtRxFull), .evtRxOverrun(evtRxOverrun)
  );
endmodule

// File: tb/tb_spi_fifo_master.sv
module tb_spi_fifo_master;
  localparam int NCS = 3;
  localparam int DEP = 16;
  localparam int DIV = 4;
  localparam int BYTE_WAIT = 8 * DIV + 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic regWrEn = 1'b0, regRdEn = 1'b0;
  logic [6:0] regAddr = '0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic sclk, mosi, ssN0, evtRxFull, evtRxOverrun;
  logic miso = 1'b0;
  logic [NCS-1:0] ssN;

  int checks = 0, errors = 0;
  bit finished = 0;

  // behavioural model state
  byte unsigned mTx[$];
  byte unsigned mRx[$];
  logic [31:0] mSsel = 32'hFFFF_FFFF;
  int expFull = 0, expOvr = 0, gotFull = 0, gotOvr = 0;
  int sclkRises = 0;

  // slave model
  byte unsigned slaveCur = 8'h3C;
  byte unsigned mosiSh = 0;
  int bitIdx = 0, slaveK = 0;
  time lastRise = 0;

  spi_fifo_master #(.NUM_CS(NCS), .DEPTH(DEP), .DIV(DIV)) dut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData),
    .sclk(sclk), .mosi(mosi), .miso(miso), .ssN(ssN),
    .evtRxFull(evtRxFull), .evtRxOverrun(evtRxOverrun)
  );

  assign ssN0 = ssN[0];

  always #5 clk = ~clk;

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // every clock: chip selects track the model, events are counted
  always @(negedge clk) begin
    if (rstN) begin
      check("R11", "ssN per clock", 32'(ssN), 32'(mSsel[NCS-1:0]));
      if (evtRxFull)    gotFull++;
      if (evtRxOverrun) gotOvr++;
    end
  end

  // slave: capture mosi and present miso on rising sclk
  initial miso = slaveCur[7];
  always @(posedge sclk) begin
    sclkRises++;
    if (bitIdx > 0)
      check("R4", "sclk period", 32'($time - lastRise), 32'(DIV * 10));
    lastRise = $time;
    mosiSh = {mosiSh[6:0], mosi};
    bitIdx++;
    if (bitIdx == 8) begin
      if (mTx.size() > 0) check("R4", "mosi byte", 32'(mosiSh), 32'(mTx.pop_front()));
      else check("R4", "unexpected byte", 32'(mosiSh), 32'hFFFF);
      if (mRx.size() < DEP) begin
        mRx.push_back(slaveCur);
        if (mRx.size() == DEP) expFull++;
      end else begin
        expOvr++;
      end
      slaveK++;
      slaveCur = byte'(8'h3C + slaveK * 7);
      bitIdx = 0;
    end
    miso = slaveCur[7 - bitIdx];
  end

  task automatic regWrite(input logic [6:0] a, input logic [31:0] d);
    @(negedge clk);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(posedge clk);
    if (a == 7'h70) mSsel = d;
    if (a == 7'h40 && d == 32'hA) begin mSsel = '1; mTx.delete(); mRx.delete(); end
    if (a == 7'h60 && d[5]) mTx.delete();
    if (a == 7'h60 && d[6]) mRx.delete();
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic pushTx(input logic [31:0] d);
    if (mTx.size() < DEP) mTx.push_back(d[7:0]);
    regWrite(7'h68, d);
  endtask

  task automatic regRead(input logic [6:0] a, output logic [31:0] d);
    @(negedge clk);
    regAddr = a; regRdEn = 1'b1;
    #1 d = regRdData;
    @(posedge clk);
    @(negedge clk);
    regRdEn = 1'b0;
  endtask

  task automatic expectReg(input string req, input logic [6:0] a, input logic [31:0] exp);
    logic [31:0] v;
    regRead(a, v);
    check(req, $sformatf("reg %h", a), v, exp);
  endtask

  task automatic expectRx(input string req);
    logic [31:0] v;
    regRead(7'h6C, v);
    if (mRx.size() == 0) check(req, "empty rx read", v, 32'hDEADBEEF);
    else check(req, "rx byte", v, 32'(mRx.pop_front()));
  endtask

  task automatic settle(input int n);
    repeat (n) @(posedge clk);
  endtask

  initial begin
    int rises;
    settle(3);
    @(negedge clk) rstN = 1'b1;
    settle(2);

    // R1 reset values, R7 status encoding, R10 occupancy at empty
    expectReg("R1", 7'h60, 32'h0);
    expectReg("R1", 7'h64, 32'h5);
    expectReg("R10", 7'h74, 32'h0);
    expectReg("R10", 7'h78, 32'h0);
    expectReg("R1", 7'h70, 32'hFFFF_FFFF);
    check("R1", "ssN after reset", 32'(ssN), 32'(3'b111));

    // R11 chip selects follow the select register
    regWrite(7'h70, 32'h5);
    check("R11", "ssN pattern", 32'(ssN), 32'(3'b101));
    expectReg("R11", 7'h70, 32'h5);

    // R5 inhibit holds bytes; R3 low byte queued; R10 occupancy
    regWrite(7'h60, 32'h100);
    rises = sclkRises;
    pushTx(32'h1A5); pushTx(32'h2B6); pushTx(32'hC7);
    settle(100);
    check("R5", "no sclk while inhibited", 32'(sclkRises), 32'(rises));
    expectReg("R10", 7'h74, 32'h2);
    expectReg("R7", 7'h64, 32'h1);

    // R6 transmit flush, bit not stored
    regWrite(7'h60, 32'h120);
    expectReg("R6", 7'h60, 32'h100);
    expectReg("R6", 7'h74, 32'h0);
    expectReg("R6", 7'h64, 32'h5);

    // R4/R5 drain on clearing inhibit
    pushTx(32'h13); pushTx(32'hC8); pushTx(32'h7E);
    regWrite(7'h60, 32'h0);
    settle(3 * BYTE_WAIT);
    check("R5", "queue drained", 32'(mTx.size()), 32'h0);
    expectReg("R10", 7'h78, 32'h2);
    expectReg("R7", 7'h64, 32'h4);
    expectRx("R4"); expectRx("R4"); expectRx("R4");
    expectRx("R9");
    expectReg("R9", 7'h78, 32'h0);
    expectReg("R9", 7'h64, 32'h5);

    // R3 full transmit queue drops further writes
    regWrite(7'h60, 32'h100);
    for (int i = 0; i < DEP; i++) pushTx(32'(i * 17 + 1));
    expectReg("R7", 7'h64, 32'h9);
    pushTx(32'hFF);
    expectReg("R3", 7'h74, 32'(DEP - 1));
    regWrite(7'h60, 32'h0);
    settle(DEP * BYTE_WAIT);
    check("R3", "all queued bytes sent", 32'(mTx.size()), 32'h0);
    expectReg("R7", 7'h64, 32'h6);
    check("R8", "full event count", 32'(gotFull), 32'(expFull));

    // R8 overrun on full receive queue
    pushTx(32'h55);
    settle(BYTE_WAIT);
    check("R8", "overrun event count", 32'(gotOvr), 32'(expOvr));
    check("R8", "overrun expected once", 32'(expOvr), 32'h1);
    expectReg("R8", 7'h78, 32'(DEP - 1));
    expectRx("R8");

    // R6 receive flush
    regWrite(7'h60, 32'h40);
    expectReg("R6", 7'h78, 32'h0);
    expectReg("R6", 7'h60, 32'h0);
    expectRx("R9");

    // R7 status writes ignored
    regWrite(7'h64, 32'hFFFF_FFFF);
    expectReg("R7", 7'h64, 32'h5);

    // R2 soft reset only on the magic word
    regWrite(7'h70, 32'h2);
    regWrite(7'h60, 32'h100);
    pushTx(32'h99);
    regWrite(7'h40, 32'h5);
    expectReg("R2", 7'h70, 32'h2);
    expectReg("R2", 7'h60, 32'h100);
    expectReg("R2", 7'h74, 32'h0);
    regWrite(7'h40, 32'hA);
    expectReg("R2", 7'h60, 32'h0);
    expectReg("R2", 7'h70, 32'hFFFF_FFFF);
    expectReg("R2", 7'h64, 32'h5);
    check("R2", "ssN released", 32'(ssN), 32'(3'b111));
    settle(2 * BYTE_WAIT);
    check("R2", "flushed byte not sent", 32'(slaveK), 32'(DEP + 4));

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule